// File: doc/BRIEF.md
# Serial Slave Byte Front End with Pause Control

This block is the pin-side front end of a serial memory slave. It receives select, serial clock, serial data in and an active-low pause (hold) input. It drives a serial data output together with a separate output enable that the pad uses for tri-state control. The block works in both clock polarities where data is captured on the rising clock edge: clock idle low (mode 0) and clock idle high (mode 3). Bits go most significant first in both directions. Each completed received byte goes to the command layer with a one-cycle valid strobe. The byte to send is taken from a load port, and a one-cycle strobe marks each load.

All pins are brought into the system clock domain through synchronizer chains. Edge detection then runs on the synchronized copies, so the serial clock must be several times slower than the system clock. A low level on the hold input pauses the transfer at a clock-low point without losing the bit position. Select overrides everything else, including an active pause. When select rises, a strobe reports whether the transfer ended on a byte boundary.

Top module: `spi_fe_top`

## Requirements
- R1: The serial input is captured on each rising serial-clock edge, most significant bit first. After the eighth captured bit, `rx_valid_o` pulses for exactly one cycle, and `rx_byte_o` holds the byte with the first captured bit in bit 7.
- R2: When select falls, the block loads `tx_byte_i`, drives its bit 7 on `miso_o` and pulses `tx_take_o`. Later bits change only in the cycle after a falling serial-clock edge. The falling edge that starts each later byte loads `tx_byte_i` again and pulses `tx_take_o` again.
- R3: Mode 0 and mode 3 both carry the same bytes in both directions. In mode 3, the first falling edge of the first byte keeps the already loaded byte instead of loading again.
- R4: A hold asserted while the serial clock is low pauses the transfer at once.
- R5: A hold asserted while the serial clock is high delays the pause until the next falling edge. That falling edge still advances the output bit.
- R6: While hold is low, `miso_oe_o` is 0, whatever the pause state.
- R7: While paused, clock edges and serial input are ignored and the bit count is kept. The pause ends only when hold is high while the serial clock is low. Shifting then continues from the same bit.
- R8: Select high clears the pause, the bit count and the output enable, and it does so even while paused. The next selection starts a fresh byte.
- R9: When select rises, `end_o` pulses for one cycle. `end_aligned_o` is 1 in that cycle only if the count stood on a byte boundary (0 or a multiple of 8 bits captured).
- R10: After reset, `miso_oe_o`, `rx_valid_o`, `tx_take_o` and `end_o` are 0.
- R11: With the default of two synchronizer stages and hold high, `miso_oe_o` rises after the second system-clock edge that samples select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| csn_i | input | 1 | Active-low select pin |
| holdn_i | input | 1 | Active-low pause pin |
| mosi_i | input | 1 | Serial data in pin |
| tx_byte_i | input | BYTE_W | Next byte to transmit |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out pad |
| tx_take_o | output | 1 | Pulse: tx_byte_i was loaded |
| rx_byte_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | Pulse: rx_byte_o is new |
| end_o | output | 1 | Pulse: select rose |
| end_aligned_o | output | 1 | With end_o: transfer ended on a byte boundary |

## Verification
The bench targets a hold asserted while the clock is high. A design that pauses at once would skip one output bit. A design that ignores the deferral would keep shifting while the output is off. The bench releases hold while the clock is high and toggles the clock during a pause. A design that released too early, or counted the ignored edges, would deliver a shifted byte. It also raises select in the middle of a pause. A design that kept the pause or the partial count would corrupt the next transfer and report a wrong boundary flag. Mode 3 runs check that the first falling edge does not reload the transmit byte, which would otherwise send a byte the command layer had already replaced.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // Synchronized pin bundle, one bit per pin.
  typedef struct packed {
    logic sck;
    logic csn;
    logic holdn;
    logic mosi;
  } pins_t;

  localparam int PIN_W = $bits(pins_t);

  // Idle pin levels that the synchronizers assume out of reset.
  localparam pins_t PIN_IDLE = '{sck: 1'b0, csn: 1'b1, holdn: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_s,
  input  logic sck_s,
  input  logic holdn_s,
  output logic paused_o
);

  logic paused_q, paused_d;

  // A pause is entered or left only while the clock is low. When hold is
  // asserted with the clock high, entry waits until the clock falls; the
  // shifter still acts on that edge because it looks at the old state.
  always_comb begin
    paused_d = paused_q;
    if (csn_s) begin
      paused_d = 1'b0;
    end else if (!paused_q) begin
      if (!holdn_s && !sck_s) paused_d = 1'b1;
    end else if (holdn_s && !sck_s) begin
      paused_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused_q <= 1'b0;
    else        paused_q <= paused_d;
  end

  assign paused_o = paused_q;

  // R4: a pause only starts from a selected cycle with hold low
  a_r4_pause_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_q) |-> $past(!holdn_s && !csn_s));

  // R7: a pause only ends through deselect or hold high with clock low
  a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused_q) |-> ($past(csn_s) || $past(holdn_s && !sck_s)));

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              paused_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              tx_take_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              end_o,
  output logic              end_aligned_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] txsh_q, txsh_d, rxsh_q, rxsh_d, rxb_q, rxb_d;
  logic              miso_q, miso_d, fresh_q, fresh_d;
  logic              rxv_q, rxv_d, take_q, take_d, end_q, end_d, al_q, al_d;
  logic              act, rx_load, tx_load;

  assign act     = !csn_s && !paused_i;
  assign tx_load = cs_fall || (act && sck_fall && cnt_q == '0 && !fresh_q);

  always_comb begin
    cnt_d   = cnt_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    rxb_d   = rxb_q;
    miso_d  = miso_q;
    fresh_d = fresh_q;
    rx_load = 1'b0;
    take_d  = 1'b0;
    end_d   = 1'b0;
    al_d    = 1'b0;
    if (csn_s) begin
      cnt_d   = '0;
      fresh_d = 1'b0;
      if (cs_rise) begin
        end_d = 1'b1;
        al_d  = (cnt_q == '0);
      end
    end else begin
      if (tx_load) begin
        miso_d  = tx_byte_i[BYTE_W-1];
        txsh_d  = {tx_byte_i[BYTE_W-2:0], 1'b0};
        take_d  = 1'b1;
        fresh_d = cs_fall;
      end else if (act && sck_fall && !(cnt_q == '0 && fresh_q)) begin
        miso_d = txsh_q[BYTE_W-1];
        txsh_d = {txsh_q[BYTE_W-2:0], 1'b0};
      end
      if (act && sck_rise) begin
        rxsh_d  = {rxsh_q[BYTE_W-2:0], mosi_s};
        fresh_d = 1'b0;
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          rx_load = 1'b1;
          rxb_d   = {rxsh_q[BYTE_W-2:0], mosi_s};
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    rxv_d = rx_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      miso_q  <= 1'b0;
      fresh_q <= 1'b0;
      rxv_q   <= 1'b0;
      take_q  <= 1'b0;
      end_q   <= 1'b0;
      al_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      txsh_q  <= txsh_d;
      rxsh_q  <= rxsh_d;
      miso_q  <= miso_d;
      fresh_q <= fresh_d;
      rxv_q   <= rxv_d;
      take_q  <= take_d;
      end_q   <= end_d;
      al_q    <= al_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rxb_q <= '0;
    else if (rx_load) rxb_q <= rxb_d;
  end

  assign miso_o        = miso_q;
  assign tx_take_o     = take_q;
  assign rx_byte_o     = rxb_q;
  assign rx_valid_o    = rxv_q;
  assign end_o         = end_q;
  assign end_aligned_o = al_q;

  // R1: the byte strobe never lasts two cycles
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);

  // R7: a selected, paused cycle leaves the bit count untouched
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_i && !csn_s) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              holdn_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              tx_take_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              end_o,
  output logic              end_aligned_o
);

  import spi_fe_pkg::*;

  pins_t pins_raw, pins_s;
  logic  sck_d, csn_d, paused;
  logic  sck_rise, sck_fall, cs_rise, cs_fall;

  assign pins_raw = '{sck: sck_i, csn: csn_i, holdn: holdn_i, mosi: mosi_i};

  spi_fe_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  // Previous synchronized levels for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= PIN_IDLE.sck;
      csn_d <= PIN_IDLE.csn;
    end else begin
      sck_d <= pins_s.sck;
      csn_d <= pins_s.csn;
    end
  end

  assign sck_rise = pins_s.sck && !sck_d;
  assign sck_fall = !pins_s.sck && sck_d;
  assign cs_rise  = pins_s.csn && !csn_d;
  assign cs_fall  = !pins_s.csn && csn_d;

  spi_fe_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_s   (pins_s.csn),
    .sck_s   (pins_s.sck),
    .holdn_s (pins_s.holdn),
    .paused_o(paused)
  );

  spi_fe_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_s        (pins_s.csn),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .sck_rise     (sck_rise),
    .sck_fall     (sck_fall),
    .mosi_s       (pins_s.mosi),
    .paused_i     (paused),
    .tx_byte_i    (tx_byte_i),
    .miso_o       (miso_o),
    .tx_take_o    (tx_take_o),
    .rx_byte_o    (rx_byte_o),
    .rx_valid_o   (rx_valid_o),
    .end_o        (end_o),
    .end_aligned_o(end_aligned_o)
  );

  // Hold forces high impedance even before the pause is taken
  assign miso_oe_o = !pins_s.csn && !paused && pins_s.holdn;

  // R5: hold seen low on a selected falling edge ends in a pause
  a_r5_deferred_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !pins_s.holdn && !pins_s.csn && !paused) |=> paused);

  // R8: a deselected cycle is never followed by an enabled output
  a_r8_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s.csn && csn_i) |=> !miso_oe_o);

endmodule

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck_i = 1'b0, csn_i = 1'b1, holdn_i = 1'b1, mosi_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic [7:0] tx_next = 8'h00;
  logic       miso_o, miso_oe_o, tx_take_o, rx_valid_o, end_o, end_aligned_o;
  logic [7:0] rx_byte_o;

  int  total = 0, bad = 0;
  bit  done = 1'b0;
  byte rxq[$];
  int  last_al = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fe_top dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i), .holdn_i(holdn_i),
    .mosi_i(mosi_i), .tx_byte_i(tx_byte_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .tx_take_o(tx_take_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .end_o(end_o), .end_aligned_o(end_aligned_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // Pin samples travel through two stages of delay, then one of history.
  int st1[4], st2[4], hist[4];          // 0 sck, 1 csn, 2 hold, 3 mosi
  int m_paused, m_cnt, m_fresh, m_tx, m_miso, m_rxsh, m_rxb;
  int m_rxv, m_take, m_end, m_al, m_oe;
  int rise, fall, csf, csr, act;

  always @(posedge clk) begin
    if (!rst_n) begin
      st1 = '{0, 1, 1, 0}; st2 = '{0, 1, 1, 0}; hist = '{0, 1, 1, 0};
      m_paused = 0; m_cnt = 0; m_fresh = 0; m_tx = 0; m_miso = 0;
      m_rxsh = 0; m_rxb = 0; m_rxv = 0; m_take = 0; m_end = 0; m_al = 0; m_oe = 0;
    end else begin
      rise = (st2[0] == 1 && hist[0] == 0);
      fall = (st2[0] == 0 && hist[0] == 1);
      csf  = (st2[1] == 0 && hist[1] == 1);
      csr  = (st2[1] == 1 && hist[1] == 0);
      act  = (st2[1] == 0 && m_paused == 0);
      m_rxv = 0; m_take = 0; m_end = 0; m_al = 0;
      if (st2[1] == 1) begin
        if (csr) begin m_end = 1; m_al = (m_cnt == 0); end
        m_cnt = 0; m_fresh = 0; m_paused = 0;
      end else begin
        if (csf || (act && fall && m_cnt == 0 && m_fresh == 0)) begin
          m_miso = (tx_byte_i >> 7) & 1; m_tx = (tx_byte_i << 1) & 255;
          m_take = 1; m_fresh = csf;
        end else if (act && fall && !(m_cnt == 0 && m_fresh == 1)) begin
          m_miso = (m_tx >> 7) & 1; m_tx = (m_tx << 1) & 255;
        end
        if (act && rise) begin
          m_rxsh = ((m_rxsh << 1) | st2[3]) & 255;
          m_fresh = 0;
          if (m_cnt == 7) begin m_cnt = 0; m_rxv = 1; m_rxb = m_rxsh; end
          else m_cnt = m_cnt + 1;
        end
        if (m_paused == 0) begin
          if (st2[2] == 0 && st2[0] == 0) m_paused = 1;
        end else if (st2[2] == 1 && st2[0] == 0) m_paused = 0;
      end
      hist = st2; st2 = st1;
      st1 = '{int'(sck_i), int'(csn_i), int'(holdn_i), int'(mosi_i)};
      m_oe = (st2[1] == 0 && m_paused == 0 && st2[2] == 1);
    end
  end

  // Every-cycle comparison and capture of strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(miso_oe_o == m_oe, "R6", "output enable", miso_oe_o, m_oe);
      if (m_oe) check(miso_o == m_miso, "R2", "serial out bit", miso_o, m_miso);
      check(rx_valid_o == m_rxv, "R1", "byte strobe", rx_valid_o, m_rxv);
      if (m_rxv) check(rx_byte_o == m_rxb, "R1", "byte value", rx_byte_o, m_rxb);
      check(tx_take_o == m_take, "R2", "load strobe", tx_take_o, m_take);
      check(end_o == m_end, "R9", "end strobe", end_o, m_end);
      if (m_end) check(end_aligned_o == m_al, "R9", "boundary flag", end_aligned_o, m_al);
      if (rx_valid_o) rxq.push_back(rx_byte_o);
      if (end_o) last_al = end_aligned_o;
      if (tx_take_o) tx_byte_i = tx_next;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic g);
    if (sck_i) begin @(negedge clk); sck_i = 1'b0; end
    @(negedge clk); mosi_i = b;
    wait_n(HALF);
    g = miso_o;
    sck_i = 1'b1;
    wait_n(HALF);
  endtask

  task automatic xfer_byte(input logic [7:0] d, output logic [7:0] g);
    for (int i = 7; i >= 0; i--) begin
      logic gb;
      xfer_bit(d[i], gb);
      g[i] = gb;
    end
  endtask

  task automatic deselect();
    if (sck_i) begin @(negedge clk); sck_i = 1'b0; wait_n(HALF); end
    @(negedge clk); csn_i = 1'b1;
    wait_n(HALF);
  endtask

  initial begin
    logic [7:0] g1, g2;
    logic       gb;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R10: quiet after reset
    check(miso_oe_o == 1'b0, "R10", "oe after reset", miso_oe_o, 0);
    check(rx_valid_o == 1'b0, "R10", "strobe after reset", rx_valid_o, 0);
    check(tx_take_o == 1'b0 && end_o == 1'b0, "R10", "load/end after reset", tx_take_o, 0);

    // R11: enable appears after the second edge that samples select low
    tx_byte_i = 8'h96; tx_next = 8'h5B;
    @(negedge clk); csn_i = 1'b0;
    @(posedge clk); #1;
    check(miso_oe_o == 1'b0, "R11", "oe after first edge", miso_oe_o, 0);
    @(posedge clk); #1;
    check(miso_oe_o == 1'b1, "R11", "oe after second edge", miso_oe_o, 1);
    wait_n(HALF);

    // R1 R2: mode 0, two bytes
    rxq.delete();
    xfer_byte(8'hA5, g1);
    xfer_byte(8'h3C, g2);
    deselect();
    check(rxq.size() == 2, "R1", "mode0 byte count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      check(rxq[0] == 8'hA5, "R1", "mode0 rx byte0", rxq[0], 8'hA5);
      check(rxq[1] == 8'h3C, "R1", "mode0 rx byte1", rxq[1], 8'h3C);
    end
    check(g1 == 8'h96, "R2", "mode0 tx byte0", g1, 8'h96);
    check(g2 == 8'h5B, "R2", "mode0 tx byte1", g2, 8'h5B);
    check(last_al == 1, "R9", "aligned end", last_al, 1);

    // R3: mode 3 (clock idle high), loaded byte changes after the take
    @(negedge clk); sck_i = 1'b1; wait_n(HALF);
    tx_byte_i = 8'hC3; tx_next = 8'h0F;
    rxq.delete();
    @(negedge clk); csn_i = 1'b0; wait_n(HALF);
    xfer_byte(8'h71, g1);
    @(negedge clk); csn_i = 1'b1; wait_n(HALF);
    check(rxq.size() == 1 && rxq[0] == 8'h71, "R3", "mode3 rx byte",
          rxq.size() == 1 ? int'(rxq[0]) : -1, 8'h71);
    check(g1 == 8'hC3, "R3", "mode3 tx byte", g1, 8'hC3);
    check(last_al == 1, "R9", "mode3 aligned end", last_al, 1);
    @(negedge clk); sck_i = 1'b0; wait_n(HALF);

    // R4 R5 R6 R7: pauses in the middle of a byte
    tx_byte_i = 8'h4E; tx_next = 8'h00;
    rxq.delete();
    @(negedge clk); csn_i = 1'b0; wait_n(HALF);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        // immediate pause with clock low
        @(negedge clk); sck_i = 1'b0; wait_n(HALF);
        holdn_i = 1'b0; wait_n(4);
        check(miso_oe_o == 1'b0, "R4", "oe during low-clock pause", miso_oe_o, 0);
        mosi_i = ~mosi_i; sck_i = 1'b1; wait_n(HALF);
        sck_i = 1'b0; wait_n(HALF);
        holdn_i = 1'b1; wait_n(4);
        check(miso_oe_o == 1'b1, "R7", "oe after release", miso_oe_o, 1);
      end
      if (i == 1) begin
        // deferred pause: hold asserted with clock high
        holdn_i = 1'b0; wait_n(4);
        check(miso_oe_o == 1'b0, "R6", "oe with hold low, clock high", miso_oe_o, 0);
        sck_i = 1'b0; wait_n(HALF);
        mosi_i = ~mosi_i; sck_i = 1'b1; wait_n(HALF);
        sck_i = 1'b0; wait_n(HALF);
        sck_i = 1'b1; wait_n(HALF);
        holdn_i = 1'b1; wait_n(HALF);
        check(miso_oe_o == 1'b0, "R7", "no release with clock high", miso_oe_o, 0);
        sck_i = 1'b0; wait_n(HALF);
        check(miso_oe_o == 1'b1, "R7", "release once clock low", miso_oe_o, 1);
      end
      xfer_bit(8'hB7 >> i, gb);
      g1[i] = gb;
    end
    deselect();
    check(rxq.size() == 1 && rxq[0] == 8'hB7, "R7", "rx across pauses",
          rxq.size() == 1 ? int'(rxq[0]) : -1, 8'hB7);
    check(g1 == 8'h4E, "R5", "tx across deferred pause", g1, 8'h4E);

    // R8 R9: deselect while paused, then a clean transfer
    tx_byte_i = 8'hFF; tx_next = 8'h00;
    rxq.delete();
    @(negedge clk); csn_i = 1'b0; wait_n(HALF);
    for (int i = 0; i < 3; i++) xfer_bit(1'b1, gb);
    @(negedge clk); sck_i = 1'b0; wait_n(HALF);
    holdn_i = 1'b0; wait_n(4);
    csn_i = 1'b1; wait_n(6);
    check(last_al == 0, "R9", "unaligned end", last_al, 0);
    check(miso_oe_o == 1'b0, "R8", "oe after deselect", miso_oe_o, 0);
    holdn_i = 1'b1; wait_n(4);
    tx_byte_i = 8'h81;
    @(negedge clk); csn_i = 1'b0; wait_n(HALF);
    check(miso_oe_o == 1'b1, "R8", "oe on new select", miso_oe_o, 1);
    xfer_byte(8'h2D, g1);
    deselect();
    check(rxq.size() == 1 && rxq[0] == 8'h2D, "R8", "fresh byte after deselect",
          rxq.size() == 1 ? int'(rxq[0]) : -1, 8'h2D);
    check(g1 == 8'h81, "R8", "fresh tx after deselect", g1, 8'h81);
    check(last_al == 1, "R9", "aligned end after recovery", last_al, 1);

    wait_n(4);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule